// File: doc/BRIEF.md
# Idle and Sync Unit Generator

This block fills a switch link with filler logical units whenever no data packet is waiting. Each unit is a fixed number of 16-bit words. The block emits them in order from word 0 to the final word, and the high byte of each word goes first. A start strobe captures three choices: a sync or non-sync unit, a master or slave unit, and a three-byte header that a master unit carries in its leading bytes. The block then streams the unit over a valid/ready output. It fills in the fixed byte patterns and closes the unit with its trailer bytes.

Bytes are numbered from 0. Byte 2k is the high byte of word k and byte 2k+1 is its low byte. The final word holds the two trailer bytes. In a non-sync unit the trailer pair is a zero byte followed by a CRC-8. The CRC uses polynomial 0x07, initial value 0x00, MSB first with no reflection, and it covers every byte before it. The CRC is updated one word at a time as words are accepted. Back-pressure rules: a word is transferred on a rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the word, the last flag and all internal progress hold.

Top module: `idle_sync_gen`

## Requirements
- R1: After reset `out_valid`, `out_last` and `done` are 0.
- R2: After a start is taken, the unit's `LEN_WORDS` words appear in index order, with word 0 valid on the cycle after the start edge. Each word carries byte 2k in bits 15:8 and byte 2k+1 in bits 7:0. `out_last` is 1 on the final word only.
- R3: In a non-sync unit, bytes 6 to 11 are 0xCC. Every byte not named by R4, R5 or R6 is 0x00, including byte 2L-2.
- R4: In a non-sync slave unit (`slave_sel`=1), byte 5 is 0x07 and bytes 0 to 2 are 0x00.
- R5: In a non-sync master unit (`slave_sel`=0), byte 0 is `hdr_in[23:16]`, byte 1 is `hdr_in[15:8]` and byte 2 is `hdr_in[7:0]`.
- R6: In a non-sync unit, byte 2L-1 is the CRC-8 (polynomial 0x07, initial value 0x00, MSB first) over bytes 0 to 2L-2.
- R7: In a sync unit (`sync_sel`=1), every byte is 0xCC except byte 2L-1, which is 0x33. The header and the slave select have no effect.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle shows the same `out_word` and `out_last`, with `out_valid` still 1.
- R9: `start` is taken only while `out_valid` is 0. The selects and header are latched at that edge. A start and changed selects during a unit do not alter it.
- R10: `done` is 1 for exactly one cycle, the cycle after the final word is transferred. `out_valid` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a unit (taken while idle) |
| sync_sel | input | 1 | 1 = sync unit, 0 = non-sync idle unit |
| slave_sel | input | 1 | 1 = slave unit, 0 = master unit |
| hdr_in | input | 24 | Master header, byte 0 in bits 23:16 |
| out_word | output | 16 | Current word, earlier byte in bits 15:8 |
| out_valid | output | 1 | Word present |
| out_ready | input | 1 | Consumer accepts the word |
| out_last | output | 1 | Word is the final one of the unit |
| done | output | 1 | One-cycle pulse after the final transfer |

## Verification
The assertions assume the consumer may hold `out_ready` low for any length of time. They also assume `start` and the selects can toggle freely while a unit is in flight, and rely on the block itself to ignore them. The stimulus keeps within this. It drives a random `out_ready` every cycle and pulses `start` at random during units with fresh random selects and headers. It also adds directed units with all-zero and all-one headers and long ready stalls. Expected bytes and CRCs come from bench functions built on the latched choices.

// File: rtl/idle_sync_pkg.sv
package idle_sync_pkg;
  localparam logic [7:0] FILL_CC    = 8'hCC;
  localparam logic [7:0] SYNC_TAIL  = 8'h33;
  localparam logic [7:0] SLAVE_MARK = 8'h07;
  localparam logic [7:0] CRC_POLY   = 8'h07;
  localparam int         ALIGN_LO   = 6;
  localparam int         ALIGN_HI   = 11;
  localparam int         MARK_POS   = 5;
  localparam int         HDR_BYTES  = 3;

  typedef struct packed {
    logic        sync;
    logic        slave;
    logic [23:0] hdr;
  } unit_cfg_t;
endpackage

// File: rtl/idle_byte_pattern.sv
module idle_byte_pattern
  import idle_sync_pkg::*;
#(
  parameter int BYTES  = 64,
  parameter int BIDX_W = 6
) (
  input  logic [BIDX_W-1:0] idx,
  input  unit_cfg_t         cfg,
  output logic [7:0]        byte_out
);
  localparam int LAST_B = BYTES - 1;

  int pos;
  always_comb begin
    pos = int'(idx);
    byte_out = 8'h00;
    if (cfg.sync) begin
      byte_out = (pos == LAST_B) ? SYNC_TAIL : FILL_CC;
    end else if (!cfg.slave && pos < HDR_BYTES) begin
      byte_out = cfg.hdr[23 - 8*pos -: 8];
    end else if (cfg.slave && pos == MARK_POS) begin
      byte_out = SLAVE_MARK;
    end else if (pos >= ALIGN_LO && pos <= ALIGN_HI) begin
      byte_out = FILL_CC;
    end
  end
endmodule

// File: rtl/crc8_byte_step.sv
module crc8_byte_step
  import idle_sync_pkg::*;
(
  input  logic [7:0] crc_in,
  input  logic [7:0] data_in,
  output logic [7:0] crc_out
);
  logic [7:0] acc;
  always_comb begin
    acc = crc_in ^ data_in;
    for (int b = 0; b < 8; b++) begin
      acc = acc[7] ? ((acc << 1) ^ CRC_POLY) : (acc << 1);
    end
    crc_out = acc;
  end
endmodule

// File: rtl/idle_sync_gen.sv
module idle_sync_gen
  import idle_sync_pkg::*;
#(
  parameter int LEN_WORDS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        sync_sel,
  input  logic        slave_sel,
  input  logic [23:0] hdr_in,
  output logic [15:0] out_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_last,
  output logic        done
);
  localparam int BYTES  = 2 * LEN_WORDS;
  localparam int WIDX_W = (LEN_WORDS > 1) ? $clog2(LEN_WORDS) : 1;
  localparam int BIDX_W = WIDX_W + 1;
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(LEN_WORDS - 1);

  logic              busy_q, done_q;
  logic [WIDX_W-1:0] widx_q;
  logic [7:0]        crc_q;
  unit_cfg_t         cfg_q;

  logic [7:0] lane_byte [2];
  logic [7:0] crc_hi, crc_lo;
  logic       final_w, xfer;

  assign final_w = (widx_q == LAST_W);
  assign xfer    = busy_q && out_ready;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [BIDX_W-1:0] lane_idx;
    assign lane_idx = {widx_q, 1'(g)};
    idle_byte_pattern #(.BYTES(BYTES), .BIDX_W(BIDX_W)) u_pat (
      .idx(lane_idx), .cfg(cfg_q), .byte_out(lane_byte[g]));
  end

  crc8_byte_step u_crc_hi (.crc_in(crc_q),  .data_in(lane_byte[0]), .crc_out(crc_hi));
  crc8_byte_step u_crc_lo (.crc_in(crc_hi), .data_in(lane_byte[1]), .crc_out(crc_lo));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      widx_q <= '0;
      crc_q  <= 8'h00;
      cfg_q  <= '0;
    end else begin
      done_q <= xfer && final_w;
      if (!busy_q && start) begin
        cfg_q  <= '{sync: sync_sel, slave: slave_sel, hdr: hdr_in};
        widx_q <= '0;
        crc_q  <= 8'h00;
        busy_q <= 1'b1;
      end else if (xfer) begin
        crc_q <= crc_lo;
        if (final_w) busy_q <= 1'b0;
        else         widx_q <= widx_q + 1'b1;
      end
    end
  end

  assign out_valid = busy_q;
  assign out_last  = busy_q && final_w;
  assign done      = done_q;
  assign out_word  = {lane_byte[0],
                      (final_w && !cfg_q.sync) ? crc_hi : lane_byte[1]};

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last));

  p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> done && !out_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(out_ready && out_last) |=> out_valid && !done);

  p_sync_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_q.sync && !out_last |-> out_word == {FILL_CC, FILL_CC});
endmodule

// File: tb/idle_sync_gen_test.sv
`timescale 1ns/1ps
module idle_sync_gen_test;
  localparam int L = 32;
  localparam int NB = 2 * L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sync_sel = 1'b0, slave_sel = 1'b0;
  logic [23:0] hdr_in = '0;
  logic [15:0] out_word;
  logic out_valid, out_ready = 1'b0, out_last, done;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] exp_b [NB];

  always #2 clk = ~clk;

  idle_sync_gen #(.LEN_WORDS(L)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sync_sel(sync_sel),
    .slave_sel(slave_sel), .hdr_in(hdr_in), .out_word(out_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .done(done));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] crc_ref(input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      c ^= exp_b[i];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic void build(input bit sy, input bit sl, input logic [23:0] h);
    for (int i = 0; i < NB; i++) begin
      if (sy) exp_b[i] = (i == NB-1) ? 8'h33 : 8'hCC;
      else if (!sl && i < 3) exp_b[i] = h[23 - 8*i -: 8];
      else if (sl && i == 5) exp_b[i] = 8'h07;
      else if (i >= 6 && i <= 11) exp_b[i] = 8'hCC;
      else exp_b[i] = 8'h00;
    end
    if (!sy) exp_b[NB-1] = crc_ref(NB-1);
  endfunction

  function automatic string req_of(input bit sy, input bit sl, input int w);
    if (sy) return "R7";
    if (w == L-1) return "R6";
    if (w <= 2) return sl ? "R4" : "R5";
    return "R3";
  endfunction

  task automatic run_unit(input bit sy, input bit sl, input logic [23:0] h,
                          input int ready_pct, input bit poke);
    int w = 0;
    bit was_stall = 1'b0;
    logic [15:0] held_w = '0;
    logic [15:0] ew;
    bit got_last = 1'b0;
    build(sy, sl, h);
    @(negedge clk);
    start = 1'b1; sync_sel = sy; slave_sel = sl; hdr_in = h;
    @(negedge clk);
    start = 1'b0;
    check(out_valid === 1'b1, "R2", 32'(out_valid), 1);
    while (!got_last) begin
      if (was_stall)
        check(out_valid === 1'b1 && out_word === held_w, "R8", 32'(out_word), 32'(held_w));
      out_ready = ($urandom_range(99) < ready_pct);
      if (poke) begin
        start = $urandom_range(1); sync_sel = $urandom_range(1);
        slave_sel = $urandom_range(1); hdr_in = 24'($urandom);
      end
      ew = {exp_b[2*w], exp_b[2*w+1]};
      if (out_ready) begin
        check(out_word === ew, req_of(sy, sl, w), 32'(out_word), 32'(ew));
        check(out_last === (w == L-1), "R2", 32'(out_last), 32'(w == L-1));
        if (w == L-1) got_last = 1'b1;
        w++;
        was_stall = 1'b0;
      end else begin
        was_stall = 1'b1;
        held_w = out_word;
      end
      @(negedge clk);
    end
    start = 1'b0; out_ready = 1'b0;
    check(done === 1'b1 && out_valid === 1'b0, "R10", {done, out_valid}, 32'h2);
    @(negedge clk);
    check(done === 1'b0, "R10", 32'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h1D1E5EED));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_last === 1'b0 && done === 1'b0, "R1",
          {out_valid, out_last, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // idle start is taken only with start high; R9: no start, nothing happens
    check(out_valid === 1'b0, "R9", 32'(out_valid), 0);
    run_unit(1'b0, 1'b0, 24'hA5C33C, 100, 1'b0);
    run_unit(1'b0, 1'b1, 24'hFFFFFF, 100, 1'b0);
    run_unit(1'b1, 1'b0, 24'h123456, 100, 1'b0);
    run_unit(1'b0, 1'b0, 24'h000000, 20, 1'b1);
    run_unit(1'b0, 1'b0, 24'hFFFFFF, 50, 1'b1);
    run_unit(1'b1, 1'b1, 24'hDEADBE, 30, 1'b1);
    for (int u = 0; u < 24; u++)
      run_unit(1'($urandom_range(1)), 1'($urandom_range(1)), 24'($urandom),
               $urandom_range(90, 10), 1'($urandom_range(1)));
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule